// File: doc/BRIEF.md
# Generation-Bit Completion Ring Writer

This block sits on the device side of a completion ring shared with a host. Each cycle it may accept one completion event (a finished transmit packet or a filled receive buffer) carrying a 16-bit identifier, a length, a kind flag and an end-of-packet flag. It packs the event into one little-endian descriptor and writes it, in a single beat, to the next slot of a power-of-two ring through a plain memory write port. The block has no producer register. Instead, every descriptor carries a generation bit. The host fills the whole ring with its current generation value, and the writer always stamps the opposite value. Each time the write position passes the last slot, the value the writer stamps flips.

A configure strobe sets the ring size, given as a base-2 logarithm, and the host's initial generation value. The same strobe rewinds the write position. A write that closes a packet also raises a one-cycle notification request. The host limits how many descriptors it posts, so the writer never stalls and never checks for overrun. A received packet can occupy several consecutive descriptors. Only the last of them carries end-of-packet, and every one of them carries a length.

Top module: `cq_gen_writer`

## Requirements
- R1: After reset, no write and no notification are driven. The ring holds 2^IDX_W slots, and the first accepted event is written to slot 0 with generation bit 1, which is the inverse of a host generation of 0.
- R2: An event presented with evValid high and cfgLoad low is written exactly once, with wrEn high in the cycle after it is sampled. In every other cycle wrEn is low. Back-to-back events produce back-to-back writes.
- R3: Successive writes go to slots 0, 1, 2 and so on, up to 2^L-1, where L is the configured size logarithm. A value of L above IDX_W is treated as IDX_W. After slot 2^L-1 the next write goes to slot 0, and the writer never stalls.
- R4: On the first pass after a configure, bit 31 of every descriptor is the inverse of cfgHostGen. The bit flips after each wrap and is constant between wraps.
- R5: The descriptor word holds, from bit 31 down: bit 31 generation, bit 30 end-of-packet, bit 29 kind (1 = receive buffer, 0 = transmit tag), bits 28:16 length, bits 15:0 identifier. It is little-endian, so wrData[7:0] is the byte at the lowest address and holds the identifier's low byte. The generation bit goes out in the same beat as the rest of the descriptor.
- R6: notifyReq is high exactly in the cycles where a descriptor with end-of-packet set is written. A packet written as several descriptors raises it only on its last descriptor.
- R7: A cfgLoad cycle sets the write slot to 0 and the stamped generation to the inverse of cfgHostGen. An event presented in that same cycle is dropped and produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Configure strobe: apply size and host generation, rewind |
| cfgSizeLog2 | input | SL_W (3) | Ring size as a base-2 logarithm |
| cfgHostGen | input | 1 | Generation value the host preloaded into every slot |
| evValid | input | 1 | Completion event present |
| evIsRx | input | 1 | 1 = receive buffer identifier, 0 = transmit completion tag |
| evId | input | ID_W (16) | Tag or buffer identifier |
| evLen | input | LEN_W (13) | Byte length of this descriptor's data |
| evEop | input | 1 | Last descriptor of the packet |
| wrEn | output | 1 | Ring memory write enable |
| wrAddr | output | IDX_W (4) | Ring slot being written |
| wrData | output | DESC_W (32) | Packed little-endian descriptor |
| notifyReq | output | 1 | Notification request, one cycle per end-of-packet write |

## Verification
The bench sweeps every ring size from one slot to the largest, plus one out-of-range size, and pairs each with both host generation values. In each case it streams more than two full laps of back-to-back events, so off-by-one wrap slots and a generation flip that happens too early or too late show up as wrong addresses or wrong bit 31. The identifiers, lengths, kinds and end-of-packet flags vary from event to event. This separates every field position and the notification timing, and the multi-descriptor runs show that notification fires only on the closing descriptor. Idle gaps and a configure that coincides with an event check that no stray writes appear, that the dropped event is really lost, and that the configure rewinds the ring.

// File: rtl/cqw_pkg.sv
package cqw_pkg;
  // Per-event strobes from control to datapath
  typedef struct packed {
    logic write;   // accept and write this event
    logic wrap;    // this write uses the last slot
    logic notify;  // this write closes a packet
  } cqwStrobe_t;
endpackage

// File: rtl/cqw_ctrl.sv
module cqw_ctrl
  import cqw_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SL_W  = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [SL_W-1:0]  cfgSizeLog2,
  input  logic             cfgHostGen,
  input  logic             evValid,
  input  logic             evEop,
  output cqwStrobe_t       strobe,
  output logic [IDX_W-1:0] curIdx,
  output logic             curGen
);
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] maskQ;
  logic [IDX_W-1:0] newMask;
  logic             genQ;

  // Low L bits set; bits at or above IDX_W do not exist, which clamps L
  always_comb begin
    for (int i = 0; i < IDX_W; i++) begin
      newMask[i] = (i < int'(cfgSizeLog2));
    end
  end

  always_comb begin
    strobe.write  = evValid && !cfgLoad;
    strobe.wrap   = strobe.write && (idxQ == maskQ);
    strobe.notify = strobe.write && evEop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      genQ  <= 1'b1;
      maskQ <= '1;
    end else if (cfgLoad) begin
      idxQ  <= '0;
      genQ  <= ~cfgHostGen;
      maskQ <= newMask;
    end else if (strobe.wrap) begin
      idxQ  <= '0;
      genQ  <= ~genQ;
    end else if (strobe.write) begin
      idxQ  <= idxQ + 1'b1;
    end
  end

  assign curIdx = idxQ;
  assign curGen = genQ;

  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    (idxQ & ~maskQ) == '0);  // R3
  AST_STEP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.write && !strobe.wrap) |=> (idxQ == $past(idxQ) + 1'b1) && $stable(genQ));  // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> (idxQ == '0) && (genQ != $past(genQ)));  // R4
  AST_GEN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrap && !cfgLoad) |=> $stable(genQ));  // R4
  AST_CFG_REWIND: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (idxQ == '0) && (genQ == !$past(cfgHostGen)));  // R7
endmodule

// File: rtl/cqw_datapath.sv
module cqw_datapath
  import cqw_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ID_W   = 16,
  parameter int LEN_W  = 13,
  parameter int DESC_W = ID_W + LEN_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  cqwStrobe_t        strobe,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic              curGen,
  input  logic              evIsRx,
  input  logic [ID_W-1:0]   evId,
  input  logic [LEN_W-1:0]  evLen,
  input  logic              evEop,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DESC_W-1:0] wrData,
  output logic              notifyReq
);
  localparam int GEN_BIT  = DESC_W - 1;
  localparam int EOP_BIT  = DESC_W - 2;
  localparam int BYTES    = DESC_W / 8;

  logic [DESC_W-1:0] descWord;
  logic [DESC_W-1:0] laneWord;

  // Generation travels in the same word as the payload: one beat
  assign descWord = {curGen, evEop, evIsRx, evLen, evId};

  // Little-endian lanes: descriptor byte k lands on wrData[8k+7:8k]
  for (genvar b = 0; b < BYTES; b++) begin : gLane
    assign laneWord[8*b +: 8] = descWord[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn      <= 1'b0;
      notifyReq <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
    end else begin
      wrEn      <= strobe.write;
      notifyReq <= strobe.notify;
      if (strobe.write) begin
        wrAddr <= curIdx;
        wrData <= laneWord;
      end
    end
  end

  AST_NOTIFY_ON_EOP: assert property (@(posedge clk) disable iff (!rstN)
    notifyReq |-> (wrEn && wrData[EOP_BIT]));  // R6
  AST_EOP_NOTIFIES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[EOP_BIT]) |-> notifyReq);  // R6
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.write |=> !wrEn);  // R2
  AST_GEN_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.write |=> (wrData[GEN_BIT] == $past(curGen)));  // R5
endmodule

// File: rtl/cq_gen_writer.sv
module cq_gen_writer
  import cqw_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int ID_W   = 16,
  parameter int LEN_W  = 13,
  parameter int SL_W   = $clog2(IDX_W + 1),
  parameter int DESC_W = ID_W + LEN_W + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [SL_W-1:0]   cfgSizeLog2,
  input  logic              cfgHostGen,
  input  logic              evValid,
  input  logic              evIsRx,
  input  logic [ID_W-1:0]   evId,
  input  logic [LEN_W-1:0]  evLen,
  input  logic              evEop,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrAddr,
  output logic [DESC_W-1:0] wrData,
  output logic              notifyReq
);
  cqwStrobe_t       strobe;
  logic [IDX_W-1:0] curIdx;
  logic             curGen;

  cqw_ctrl #(.IDX_W(IDX_W), .SL_W(SL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSizeLog2(cfgSizeLog2),
    .cfgHostGen(cfgHostGen), .evValid(evValid), .evEop(evEop),
    .strobe(strobe), .curIdx(curIdx), .curGen(curGen)
  );

  cqw_datapath #(.IDX_W(IDX_W), .ID_W(ID_W), .LEN_W(LEN_W), .DESC_W(DESC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curIdx(curIdx), .curGen(curGen),
    .evIsRx(evIsRx), .evId(evId), .evLen(evLen), .evEop(evEop),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .notifyReq(notifyReq)
  );
endmodule

// File: tb/cq_gen_writer_tb.sv
`timescale 1ns/1ps
module cq_gen_writer_tb;
  localparam int IDX_W = 4, ID_W = 16, LEN_W = 13, SL_W = 3, DESC_W = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgLoad = 1'b0, cfgHostGen = 1'b0;
  logic [SL_W-1:0] cfgSizeLog2 = '0;
  logic evValid = 1'b0, evIsRx = 1'b0, evEop = 1'b0;
  logic [ID_W-1:0] evId = '0;
  logic [LEN_W-1:0] evLen = '0;
  logic wrEn, notifyReq;
  logic [IDX_W-1:0] wrAddr;
  logic [DESC_W-1:0] wrData;

  int nRun = 0, nFail = 0;
  int mIdx = 0, mSize = 16;
  logic mGen = 1'b1;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cq_gen_writer u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgSizeLog2(cfgSizeLog2),
    .cfgHostGen(cfgHostGen), .evValid(evValid), .evIsRx(evIsRx), .evId(evId),
    .evLen(evLen), .evEop(evEop), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .notifyReq(notifyReq)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doCfg(int lg, logic hg, logic withEv);
    @(negedge clk);
    cfgLoad = 1'b1; cfgSizeLog2 = SL_W'(lg); cfgHostGen = hg;
    evValid = withEv; evId = 16'hDEAD; evEop = 1'b1;
    @(posedge clk); #1;
    chk("R7", "wrEn on cfg cycle", longint'(wrEn), 0);
    chk("R7", "notify on cfg cycle", longint'(notifyReq), 0);
    cfgLoad = 1'b0; evValid = 1'b0;
    mIdx = 0; mSize = 1 << ((lg > IDX_W) ? IDX_W : lg); mGen = ~hg;
  endtask

  task automatic doEv(logic rx, logic [ID_W-1:0] id, logic [LEN_W-1:0] len, logic eop);
    logic [DESC_W-1:0] exp;
    @(negedge clk);
    evValid = 1'b1; evIsRx = rx; evId = id; evLen = len; evEop = eop;
    @(posedge clk); #1;
    exp = {mGen, eop, rx, len, id};
    chk("R2", "wrEn", longint'(wrEn), 1);
    chk("R3", "wrAddr", longint'(wrAddr), longint'(mIdx));
    chk("R4", "gen bit", longint'(wrData[31]), longint'(mGen));
    chk("R5", "descriptor", longint'(wrData), longint'(exp));
    chk("R5", "byte lane 0", longint'(wrData[7:0]), longint'(id[7:0]));
    chk("R6", "notify", longint'(notifyReq), longint'(eop));
    if (mIdx == mSize - 1) begin mIdx = 0; mGen = ~mGen; end
    else mIdx++;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    evValid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk("R2", "idle wrEn", longint'(wrEn), 0);
      chk("R6", "idle notify", longint'(notifyReq), 0);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset wrEn", longint'(wrEn), 0);
    chk("R1", "reset notify", longint'(notifyReq), 0);
    @(negedge clk); rstN = 1'b1;
    // R1: default ring of 16 slots, generation 1 first
    mIdx = 0; mSize = 16; mGen = 1'b1;
    for (int k = 0; k < 18; k++)
      doEv(k[0], 16'h1000 + 16'(k), 13'(k * 3), (k % 4) == 3);
    idle(2);
    // R3 R4 sweep over every size and both host generations
    for (int lg = 0; lg <= 5; lg++) begin
      for (int hg = 0; hg < 2; hg++) begin
        int sz;
        int lgUse;
        lgUse = (lg == 5) ? 7 : lg;
        doCfg(lgUse, hg[0], 1'b0);
        sz = 1 << ((lgUse > IDX_W) ? IDX_W : lgUse);
        for (int k = 0; k < 2 * sz + 3; k++)
          doEv(k[1], 16'hA500 ^ 16'(k * 16'h0123), 13'((k * 7 + lg) % 8192), (k % 3) == 2);
        idle(1);
      end
    end
    // R6: one packet spanning four descriptors, then a single-descriptor one
    doCfg(3, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) doEv(1'b1, 16'h0F00 + 16'(k), 13'h1FFF, k == 3);
    doEv(1'b0, 16'hFFFF, 13'h0001, 1'b1);
    idle(1);
    // R7: event coinciding with configure is dropped, ring rewinds
    doCfg(2, 1'b0, 1'b1);
    doEv(1'b0, 16'h5A5A, 13'h0040, 1'b0);
    doEv(1'b1, 16'hA5A5, 13'h0041, 1'b1);
    idle(2);
    finish();
  end
endmodule